// File: doc/BRIEF.md
# Memory-mapped random word generator

This peripheral produces 32-bit pseudo-random words and hands them to a host over a single-cycle 32-bit register port. The host sets an enable bit, may mask the interrupt, and may program a warm-up count. While enabled, a 32-bit Galois LFSR advances once per clock. At a fixed pacing interval one generated word is taken. It is either thrown away, while warm-up words remain to be discarded, or it is pushed into a small output FIFO.

Software polls the ready-word count in the top byte of the status register and then reads the data register, which pops one word per read. An interrupt output tells the host that words are waiting. The register port accepts every request in the cycle it is presented and never stalls, so there is no back-pressure at the edge. Read data is combinational from the address in the same cycle, and the pop takes effect at the following clock edge. The source is deterministic and is not meant to be secure.

Top module: `randword_mmio`

## Requirements
- R1: After reset the control, status and mask registers read 0, the FIFO is empty and `irq` is low.
- R2: Byte offset 0x00 is control. Writing it sets the enable from `bus_wdata[0]`. Reading it returns the enable in bit 0 and zeros in bits [31:1].
- R3: The generator is a right-shifting Galois LFSR with seed 0xACE12468. Each step shifts the state right by one and, if the bit shifted out was 1, XORs in 0x80200003. The generator steps once per clock while enabled. On every 32nd enabled clock, the state held just before that edge is taken as a word. After reset and enable, the first word is therefore the seed stepped 31 times.
- R4: Byte offset 0x04 is status. A read returns the number of words in the FIFO in bits [31:24] and zeros in bits [23:0].
- R5: A write to status loads a warm-up counter with `bus_wdata`. While that counter is nonzero, each taken word is discarded and the counter drops by one. A status write in the same cycle as a taken word wins over the decrement.
- R6: Byte offset 0x08 is data. A read returns the oldest FIFO word and removes it at that clock edge. A read of an empty FIFO returns 0 and leaves the count unchanged.
- R7: The FIFO holds up to 16 words. A word taken while the FIFO holds 16 words before that edge is lost, but the generator keeps stepping.
- R8: `irq` is high exactly when the FIFO is non-empty, the warm-up counter is 0 and mask bit 0 is clear.
- R9: Byte offset 0x10 is the interrupt mask. Bit 0 is written from `bus_wdata[0]` and reads back in bit 0, with zeros elsewhere.
- R10: Clearing the enable stops both the LFSR stepping and the pacing count, and keeps the FIFO contents. Setting the enable again resumes from the state where generation stopped.
- R11: Reads of any other offset (for example 0x0C, 0x01 or 0x14) return 0. Writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | A register access is presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Words-ready interrupt |

## Verification
The bench builds the block with its default parameters: a 16-word FIFO, a 32-clock pacing interval and a 32-bit warm-up counter. With these values a full FIFO is reached in roughly 520 clocks. This brings the dropped-word path and simultaneous pops against a full FIFO within a short run. Small warm-up counts mixed into random traffic also make status writes collide with taken words, which exercises both the discard path and the load-over-decrement rule.

// File: rtl/randword_pkg.sv
package randword_pkg;
  localparam int unsigned REG_CTRL   = 32'h00;
  localparam int unsigned REG_STATUS = 32'h04;
  localparam int unsigned REG_DATA   = 32'h08;
  localparam int unsigned REG_MASK   = 32'h10;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned COUNT_LSB  = 24;
  localparam int unsigned COUNT_W    = 8;

  function automatic logic [WORD_W-1:0] galois_next(input logic [WORD_W-1:0] s,
                                                     input logic [WORD_W-1:0] taps);
    logic [WORD_W-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ taps;
    return n;
  endfunction
endpackage

// File: rtl/randword_lfsr.sv
module randword_lfsr #(
  parameter int unsigned W    = 32,
  parameter logic [W-1:0] TAPS = 32'h80200003,
  parameter logic [W-1:0] SEED = 32'hACE12468
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else if (adv_i) state_q <= randword_pkg::galois_next(state_q, TAPS);
  end

  assign state_o = state_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst) state_q != '0); // R3
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst) !adv_i |=> $stable(state_q)); // R10
endmodule

// File: rtl/randword_pacer.sv
module randword_pacer #(
  parameter int unsigned PERIOD = 32,
  parameter int unsigned WARM_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [WARM_W-1:0] load_val_i,
  input  logic              room_i,
  output logic              push_o,
  output logic              warm_done_o
);
  localparam int unsigned PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0]   phase_q;
  logic [WARM_W-1:0] warm_q;
  logic              tick;

  assign tick = en_i && (phase_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else if (en_i) phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) warm_q <= '0;
    else if (load_i) warm_q <= load_val_i;
    else if (tick && (warm_q != '0)) warm_q <= warm_q - 1'b1;
  end

  assign warm_done_o = (warm_q == '0);
  assign push_o      = tick && warm_done_o && room_i;

  AST_WARM_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (tick && !warm_done_o && !load_i) |=> (warm_q == $past(warm_q) - 1'b1)); // R5
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(phase_q)); // R10
endmodule

// File: rtl/randword_fifo.sv
module randword_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;

  assign do_pop = pop_i && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop) rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      case ({push_i, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = (cnt_q != '0) ? mem[rd_q] : '0;
  assign count_o = cnt_q;

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst) cnt_q <= CNT_FULL); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push_i |-> (cnt_q != CNT_FULL)); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && (cnt_q == '0)) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/randword_mmio.sv
module randword_mmio #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned TICK_PERIOD = 32,
  parameter int unsigned WARM_W      = 32,
  parameter logic [31:0] LFSR_SEED   = 32'hACE12468,
  parameter logic [31:0] LFSR_TAPS   = 32'h80200003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import randword_pkg::*;

  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH+1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FIFO_DEPTH);

  logic             en_q, mask_q;
  logic             sel_ctrl, sel_status, sel_data, sel_mask;
  logic             wr_ctrl, wr_status, wr_mask, rd_data;
  logic [31:0]      lfsr_word, fifo_head;
  logic [CNT_W-1:0] fifo_count;
  logic             fifo_push, warm_done;
  logic [COUNT_W-1:0] count_field;

  assign sel_ctrl   = (bus_addr == ADDR_W'(REG_CTRL));
  assign sel_status = (bus_addr == ADDR_W'(REG_STATUS));
  assign sel_data   = (bus_addr == ADDR_W'(REG_DATA));
  assign sel_mask   = (bus_addr == ADDR_W'(REG_MASK));

  assign wr_ctrl   = bus_valid && bus_write && sel_ctrl;
  assign wr_status = bus_valid && bus_write && sel_status;
  assign wr_mask   = bus_valid && bus_write && sel_mask;
  assign rd_data   = bus_valid && !bus_write && sel_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (wr_ctrl) en_q   <= bus_wdata[0];
      if (wr_mask) mask_q <= bus_wdata[0];
    end
  end

  randword_lfsr #(.W(32), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .adv_i(en_q), .state_o(lfsr_word)
  );

  randword_pacer #(.PERIOD(TICK_PERIOD), .WARM_W(WARM_W)) u_pacer (
    .clk(clk), .rst(rst), .en_i(en_q), .load_i(wr_status),
    .load_val_i(bus_wdata[WARM_W-1:0]), .room_i(fifo_count != CNT_FULL),
    .push_o(fifo_push), .warm_done_o(warm_done)
  );

  randword_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst(rst), .push_i(fifo_push), .din_i(lfsr_word),
    .pop_i(rd_data), .head_o(fifo_head), .count_o(fifo_count)
  );

  assign count_field = COUNT_W'(fifo_count);

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)        bus_rdata = {31'b0, en_q};
    else if (sel_status) bus_rdata = {count_field, {COUNT_LSB{1'b0}}};
    else if (sel_data)   bus_rdata = fifo_head;
    else if (sel_mask)   bus_rdata = {31'b0, mask_q};
  end

  assign irq = (fifo_count != '0) && warm_done && !mask_q;

  AST_PUSH_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) fifo_push |-> en_q); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst) mask_q |-> !irq); // R8
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sel_data && (fifo_count == '0)) |-> (bus_rdata == '0)); // R6
endmodule

// File: tb/sim_randword_mmio.sv
module sim_randword_mmio;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int PERIOD = 32;
  localparam logic [31:0] SEED = 32'hACE12468;
  localparam logic [31:0] TAPS = 32'h80200003;

  logic clk = 0, rst = 1, bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int checks = 0, fails = 0, cyc = 0;

  randword_mmio u0 (.clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] nx(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
  endfunction

  function automatic logic [31:0] steps(input int n);
    logic [31:0] s = SEED;
    for (int i = 0; i < n; i++) s = nx(s);
    return s;
  endfunction

  // reference model, updated at each rising edge from the driven inputs
  logic m_en, m_mask;
  logic [31:0] m_warm, m_lfsr, m_word;
  int m_phase, m_sz;
  logic [31:0] m_q[$];
  logic m_tick;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_mask = 0; m_warm = 0; m_phase = 0; m_lfsr = SEED; m_q.delete();
    end else begin
      m_tick = m_en && (m_phase == PERIOD-1);
      m_sz = m_q.size();
      m_word = m_lfsr;
      if (bus_valid && !bus_write && bus_addr == 8'h08 && m_sz > 0) void'(m_q.pop_front());
      if (m_tick) begin
        if (m_warm != 0) m_warm = m_warm - 1;
        else if (m_sz < DEPTH) m_q.push_back(m_word);
      end
      if (m_en) begin
        m_lfsr = nx(m_lfsr);
        m_phase = (m_phase == PERIOD-1) ? 0 : m_phase + 1;
      end
      if (bus_valid && bus_write) begin
        if (bus_addr == 8'h00) m_en = bus_wdata[0];
        else if (bus_addr == 8'h04) m_warm = bus_wdata;
        else if (bus_addr == 8'h10) m_mask = bus_wdata[0];
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return {31'b0, m_en};
      8'h04: return {8'(m_q.size()), 24'b0};
      8'h08: return (m_q.size() > 0) ? m_q[0] : 32'h0;
      8'h10: return {31'b0, m_mask};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_q.size() > 0) && (m_warm == 0) && !m_mask;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R4";
      8'h08: return "R6";
      8'h10: return "R9";
      default: return "R11";
    endcase
  endfunction

  // called at a falling edge; completes at the next falling edge
  task automatic op(input logic wr, input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = d;
    #1;
    chk("R8 irq", {31'b0, irq}, {31'b0, exp_irq()});
    if (!wr) chk(req_of(a), bus_rdata, exp_read(a));
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_fixed(input string req, input logic [7:0] a, input logic [31:0] e);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1;
    chk(req, bus_rdata, e);
    chk(req, bus_rdata, exp_read(a));
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      #1;
      chk("R8 irq", {31'b0, irq}, {31'b0, exp_irq()});
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1; bus_valid = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    do_reset();
    // R1 reset state
    rd_fixed("R1", 8'h00, 32'h0);
    rd_fixed("R1", 8'h04, 32'h0);
    rd_fixed("R1", 8'h10, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd_fixed("R1 empty data", 8'h08, 32'h0);

    // R3 first word timing and value
    op(1, 8'h00, 32'h1);
    rd_fixed("R2 enable readback", 8'h00, 32'h1);
    idle(30);
    rd_fixed("R3 none before 32nd", 8'h04, 32'h0);
    idle(1);
    rd_fixed("R3 one word", 8'h04, 32'h0100_0000);
    rd_fixed("R3 word value", 8'h08, steps(31));
    rd_fixed("R6 empty after pop", 8'h04, 32'h0);

    // R5 warm-up discard
    do_reset();
    op(1, 8'h04, 32'd2);
    op(1, 8'h00, 32'h1);
    idle(94);
    rd_fixed("R5 discarded", 8'h04, 32'h0);
    idle(1);
    rd_fixed("R5 third kept", 8'h04, 32'h0100_0000);
    rd_fixed("R5 word value", 8'h08, steps(95));

    // R7 full FIFO, dropping
    idle(20 * PERIOD);
    rd_fixed("R7 full", 8'h04, 32'h1000_0000);
    // R10 disable keeps words
    op(1, 8'h00, 32'h0);
    idle(200);
    rd_fixed("R10 kept", 8'h04, 32'h1000_0000);
    op(0, 8'h08, 0);
    rd_fixed("R10 after pop", 8'h04, 32'h0F00_0000);
    // R11 unmapped writes ignored
    op(1, 8'h0C, 32'hFFFF_FFFF);
    op(1, 8'h01, 32'hFFFF_FFFF);
    op(1, 8'h14, 32'hFFFF_FFFF);
    rd_fixed("R11 ctrl untouched", 8'h00, 32'h0);
    rd_fixed("R11 mask untouched", 8'h10, 32'h0);
    rd_fixed("R11 unmapped read", 8'h0C, 32'h0);
    // R9 mask and R8
    op(1, 8'h10, 32'h1);
    rd_fixed("R9 mask readback", 8'h10, 32'h1);
    chk("R8 masked", {31'b0, irq}, 32'h0);
    op(1, 8'h10, 32'h0);
    chk("R8 unmasked", {31'b0, irq}, 32'h1);
    op(1, 8'h00, 32'h1);

    // random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 40) idle(1);
      else if (r < 65) op(0, 8'h08, 0);
      else if (r < 75) op(0, 8'h04, 0);
      else if (r < 80) op(1, 8'h00, {31'b0, ($urandom_range(0, 9) < 8)});
      else if (r < 84) op(1, 8'h04, $urandom_range(0, 2));
      else if (r < 88) op(1, 8'h10, {31'b0, ($urandom_range(0, 3) == 0)});
      else if (r < 93) op(0, ($urandom_range(0, 1) != 0) ? 8'h00 : 8'h10, 0);
      else begin
        logic [7:0] ua;
        case ($urandom_range(0, 3))
          0: ua = 8'h0C;
          1: ua = 8'h01;
          2: ua = 8'h14;
          default: ua = 8'h09;
        endcase
        op($urandom_range(0, 1) != 0, ua, $urandom);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule